// File: doc/BRIEF.md
# Shared-Bus Addressed Word Memory

This block is a clocked single-port store of 2048 words of 16 bits. It talks to its host over one bidirectional 16-bit bus. The bus carries an address in one phase and a data word in another. To reach a word, the host first pulses an address strobe, which captures the low 11 bus bits into an internal address register. That address stays in place for any number of later phases. In a write phase the host drives a word onto the bus with the write strobe high, and the word is stored at the held address. In a read phase the host releases the bus and raises output enable, and the memory drives the stored word back onto the bus.

A synchronous reset empties the whole store in one clock. It also sets the held address to zero. Every word then reads as zero until it is written again. The memory never drives the bus unless it is asked to, and it never drives while a write is under way. The host can therefore use the bus freely in address and write phases.

The bus has no handshake. Every phase completes in one clock, so the host never has to wait and there is no back-pressure to signal.

Top module: `muxbus_ram`

## Requirements
- R1: While `oe` is low, the block drives none of the 16 `ad` lines (high impedance). This includes the time straight after reset with all strobes low.
- R2: On a rising edge of `clk` with `ae` high and `rst` low, bits 10..0 of `ad` are captured as the held address. Bits 15..11 are ignored. The held address keeps its value on every edge where `ae` is low.
- R3: On a rising edge with `we` high and `ae` and `rst` low, the 16-bit word on `ad` is stored at the held address.
- R4: While `oe` is high and `we` is low, the block drives `ad` from a one-stage read register. That register samples the word at the held address on every rising edge. The stored word is therefore on the bus after the first rising edge with `oe` high that follows the address capture and any write to that address.
- R5: A rising edge with `rst` high clears every stored word. Until a word is written again, a read of it returns 0x0000.
- R6: A rising edge with `rst` high sets the held address to 0. Reset takes priority over `ae` and `we` on the same edge: no address is captured and nothing is stored.
- R7: While `we` is high, the block does not drive `ad`, even if `oe` is high.
- R8: When `ae` and `we` are both high on an edge, the bus value is taken as an address only, and no word is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ae | input | 1 | Address strobe: capture `ad[10:0]` as the held address |
| we | input | 1 | Write strobe: store the `ad` word at the held address |
| oe | input | 1 | Output enable: drive the read word onto `ad` |
| ad | inout | 16 | Shared address/data bus |

## Verification
A wrong held address shows on the very next read. The bus then carries a different address's word one clock after `oe` rises. A lost or misdirected write shows the same way, whenever that address is next read. The check writes a distinct computed word to every one of the 2048 addresses and reads each one back, so a mistake in any address bit or data bit cannot hide.

A stale entry surviving reset shows as a nonzero word on the first read after reset. Unwanted bus driving is caught by having the host drive zeros while the block should stay silent. Any contention then shows up on the bus in that same cycle.

// File: rtl/muxbus_ram_pkg.sv
`timescale 1ns/1ps
package muxbus_ram_pkg;
  parameter int unsigned MB_ADDR_W = 11;
  parameter int unsigned MB_DATA_W = 16;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_WRITE = 2'd2,
    PH_READ  = 2'd3
  } mb_phase_e;
endpackage

// File: rtl/muxbus_ram_addr.sv
`timescale 1ns/1ps
module muxbus_ram_addr #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [ADDR_W-1:0] bus_lo,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst)      addr_q <= '0;
    else if (cap) addr_q <= bus_lo;
  end

  assert_addr_reset_R6: assert property (@(posedge clk) rst |=> (addr_q == '0))
    else $error("held address not zero after reset");
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(addr_q))
    else $error("held address moved without strobe");
endmodule

// File: rtl/muxbus_ram_store.sv
`timescale 1ns/1ps
module muxbus_ram_store #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_go,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_q
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld;

  always_ff @(posedge clk) begin
    if (wr_go) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        vld <= '0;
    else if (wr_go) vld[addr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)            rd_q <= '0;
    else if (vld[addr]) rd_q <= mem[addr];
    else                rd_q <= '0;
  end

  assert_store_marks_R3: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> vld[$past(addr)])
    else $error("written word not marked present");
  assert_read_reset_R5: assert property (@(posedge clk) rst |=> (rd_q == '0 && vld == '0))
    else $error("store not empty after reset");
endmodule

// File: rtl/muxbus_ram_drv.sv
`timescale 1ns/1ps
module muxbus_ram_drv (
  input  logic oe,
  input  logic we,
  output logic drv_en,
  output muxbus_ram_pkg::mb_phase_e phase
);
  import muxbus_ram_pkg::*;

  always_comb begin
    drv_en = oe & ~we;
    if (we)      phase = PH_WRITE;
    else if (oe) phase = PH_READ;
    else         phase = PH_IDLE;
  end

  always_comb begin
    assert_quiet_R1: assert (oe || !drv_en) else $error("drive with oe low");
    assert_nofight_R7: assert (!we || !drv_en) else $error("drive during write");
  end
endmodule

// File: rtl/muxbus_ram.sv
`timescale 1ns/1ps
module muxbus_ram #(
  parameter int unsigned ADDR_W = muxbus_ram_pkg::MB_ADDR_W,
  parameter int unsigned DATA_W = muxbus_ram_pkg::MB_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ae,
  input  logic              we,
  input  logic              oe,
  inout  wire  [DATA_W-1:0] ad
);
  import muxbus_ram_pkg::*;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rd_q;
  logic              drv_en;
  logic              wr_go;
  mb_phase_e         phase;

  // R8: address strobe wins over write; R6: reset wins over both
  assign wr_go = we & ~ae & ~rst;

  muxbus_ram_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .cap(ae), .bus_lo(ad[ADDR_W-1:0]), .addr_q(addr_q)
  );

  muxbus_ram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .wr_go(wr_go), .addr(addr_q), .wdata(ad), .rd_q(rd_q)
  );

  muxbus_ram_drv u_drv (.oe(oe), .we(we), .drv_en(drv_en), .phase(phase));

  assign ad = drv_en ? rd_q : {DATA_W{1'bz}};

  assert_addr_first_R8: assert property (@(posedge clk) disable iff (rst)
    ae |-> (phase != PH_WRITE || !wr_go))
    else $error("store fired during address strobe");
endmodule

// File: tb/muxbus_ram_bench.sv
`timescale 1ns/1ps
module muxbus_ram_bench;
  logic clk = 1'b0;
  logic rst = 1'b1, ae = 1'b0, we = 1'b0, oe = 1'b0;
  logic host_en = 1'b0;
  logic [15:0] host_drv = 16'h0;
  wire  [15:0] ad;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  assign ad = host_en ? host_drv : 16'hzzzz;

  always #2 clk = ~clk;

  muxbus_ram u_muxbus_ram (.clk(clk), .rst(rst), .ae(ae), .we(we), .oe(oe), .ad(ad));

  function automatic logic [15:0] patt(input int a);
    return 16'((a * 40503 + 4660) & 16'hFFFF) | 16'h0001;
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic latch(input logic [15:0] v);
    host_en = 1'b1; host_drv = v; ae = 1'b1;
    @(negedge clk);
    ae = 1'b0; host_en = 1'b0;
  endtask

  task automatic write(input logic [15:0] d);
    host_en = 1'b1; host_drv = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; host_en = 1'b0;
  endtask

  task automatic read_chk(input logic [15:0] exp, input string req);
    oe = 1'b1;
    @(negedge clk);
    check(ad, exp, req);
    oe = 1'b0;
  endtask

  task automatic quiet_chk(input string req);
    host_en = 1'b1; host_drv = 16'h0000;
    #1 check(ad, 16'h0000, req);
    @(negedge clk);
    host_en = 1'b0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 idle after reset, R5 empty store, R6 address zero
    quiet_chk("R1 idle after reset");
    read_chk(16'h0000, "R5 empty after reset");
    // full sweep: R2 capture, R3 write, R4 read
    for (int a = 0; a < 2048; a++) begin
      latch(16'(a));
      write(patt(a));
    end
    for (int a = 0; a < 2048; a++) begin
      latch(16'(a));
      read_chk(patt(a), "R4 readback sweep");
    end
    // R2 upper bits ignored
    for (int k = 0; k < 32; k++) begin
      int a = (k * 67 + 5) % 2048;
      latch(16'((k << 11) | a));
      read_chk(patt(a), "R2 upper bits ignored");
    end
    latch(16'd2047);
    read_chk(patt(2047), "R4 top address");
    // R2 hold across idle cycles
    latch(16'd0);
    @(negedge clk); @(negedge clk);
    read_chk(patt(0), "R2 address held");
    // R1 idle with nonzero word ready
    latch(16'd9);
    @(negedge clk);
    quiet_chk("R1 idle with data ready");
    // R7 write with oe high: no drive
    oe = 1'b1; we = 1'b1;
    quiet_chk("R7 no drive during write");
    oe = 1'b0; we = 1'b0;
    read_chk(16'h0000, "R3 zero word stored");
    // R8 ae and we together: address only
    latch(16'd100);
    ae = 1'b1; we = 1'b1; host_en = 1'b1; host_drv = 16'd200;
    @(negedge clk);
    ae = 1'b0; we = 1'b0; host_en = 1'b0;
    read_chk(patt(200), "R8 address taken, 200 unchanged");
    latch(16'd100);
    read_chk(patt(100), "R8 100 unchanged");
    // R6 reset priority over ae/we
    latch(16'd5);
    rst = 1'b1; ae = 1'b1; we = 1'b1; host_en = 1'b1; host_drv = 16'd7;
    @(negedge clk);
    rst = 1'b0; ae = 1'b0; we = 1'b0; host_en = 1'b0;
    quiet_chk("R1 idle after second reset");
    write(16'hBEEF);
    latch(16'd0);
    read_chk(16'hBEEF, "R6 address reset to zero");
    for (int a = 1; a < 2048; a += 73) begin
      latch(16'(a));
      read_chk(16'h0000, "R5 cleared after reset");
    end
    latch(16'd2047);
    read_chk(16'h0000, "R5 top cleared");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule